// File: doc/BRIEF.md
# Match-Compare Operating-System Timer

This block is a memory-mapped system timer with one 32-bit match value. Software writes a target value into the match register. The block then loads a countdown with the distance from its last recorded counter value to that target, and 32-bit wraparound is taken into account. The countdown steps down once on every cycle in which `tick_en` is high. When it expires, the recorded counter value jumps to the match value. If the interrupt-enable register holds any nonzero value, a status flag is set, and the level interrupt output follows that flag. Software acknowledges the interrupt by writing zero to the status register.

Reading the counter location does not read a stored counter. The value returned is the match value minus the count still remaining. While the timer is armed, this reading moves up toward the match value. Once the timer is idle, the reading equals the match value.

The countdown is a two-state machine. `CD_IDLE` is the reset state and the state after an expiry. `CD_RUN` means the timer is armed and counting. The transitions are:
- `arm`: a match write, taken from either state, which enters `CD_RUN` with a freshly computed distance.
- `step`: a tick while in `CD_RUN` with more than one count left, which stays in `CD_RUN`.
- `expire`: a tick while in `CD_RUN` with one or zero counts left, which returns to `CD_IDLE`.
- `wait`: a cycle with no tick and no match write, which holds the current state.

Top module: `match_timer`

## Requirements
- R1: After reset, reads of match (byte offset 0x00), counter (0x10), status (0x14) and interrupt enable (0x1C) all return 0, `irq` is low, and the countdown is idle.
- R2: Interrupt enable is a full 32-bit read/write register. The counter offset ignores writes. Every other offset, including any address with bits [1:0] nonzero, reads 0 and ignores writes. Status reads back as 0 or 1 in bit 0.
- R3: A match write with value M, when the recorded counter value is C, loads the remaining count with M−C if M>C, and with M+(0xFFFFFFFF−C) otherwise (modulo 2^32). The counter offset always reads M minus the remaining count.
- R4: While armed, the remaining count drops by exactly one on each clock edge where `tick_en` is high, and it holds on edges where `tick_en` is low.
- R5: A countdown loaded with N≥1 expires on the N-th enabled tick, and one loaded with 0 expires on the first. On expiry, the recorded counter value becomes M and the countdown goes idle. The counter reading stays at M until the next match write.
- R6: On expiry with a nonzero interrupt enable, status becomes 1 and `irq` goes high at that same clock edge. With enable equal to zero, status and `irq` remain unchanged.
- R7: Writing 0 to status clears status and `irq` at the next edge. A nonzero write to status is ignored. If an expiry that sets status coincides with a clearing write, status ends at 1.
- R8: Changing interrupt enable never changes a pending status or `irq`.
- R9: A match write re-arms the countdown even while it is running. The distance is computed from the counter value recorded at the last expiry, not from the live reading. A match write on the same edge as an expiring tick cancels that expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Countdown step enable, one decrement per high cycle |
| bus_wr | input | 1 | Write strobe for a full 32-bit word |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
A corrupted remaining count shows up directly at the counter read offset, because that reading is the match value minus the remaining count. It also moves the expiry edge, and with it the rise of `irq`, by the same number of ticks. A wrong recorded counter value stays hidden while the timer is idle. It becomes visible on the next match write, as a wrong counter reading in the cycle right after that write. A stuck state register appears either as counter readings that keep advancing after expiry or as an `irq` that never rises. The bench therefore reads the counter after every tick burst, at exact tick counts on both sides of each expiry.

// File: rtl/mt_pkg.sv
package mt_pkg;

    typedef enum logic {
        CD_IDLE = 1'b0,
        CD_RUN  = 1'b1
    } cd_state_t;

    localparam logic [7:0] OFF_MATCH  = 8'h00;
    localparam logic [7:0] OFF_COUNT  = 8'h10;
    localparam logic [7:0] OFF_STATUS = 8'h14;
    localparam logic [7:0] OFF_IEN    = 8'h1C;

endpackage

// File: rtl/mt_regfile.sv
module mt_regfile
    import mt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] remaining,
    input  logic              status,
    output logic              wr_match,
    output logic              wr_status,
    output logic [DATA_W-1:0] match_q,
    output logic [DATA_W-1:0] ien_q,
    output logic [DATA_W-1:0] bus_rdata
);

    logic wr_ien;

    always_comb begin
        wr_match  = bus_wr && (bus_addr == ADDR_W'(OFF_MATCH));
        wr_status = bus_wr && (bus_addr == ADDR_W'(OFF_STATUS));
        wr_ien    = bus_wr && (bus_addr == ADDR_W'(OFF_IEN));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            ien_q   <= '0;
        end else begin
            if (wr_match) match_q <= bus_wdata;
            if (wr_ien)   ien_q   <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_MATCH))       bus_rdata = match_q;
        else if (bus_addr == ADDR_W'(OFF_COUNT))  bus_rdata = match_q - remaining;
        else if (bus_addr == ADDR_W'(OFF_STATUS)) bus_rdata = DATA_W'(status);
        else if (bus_addr == ADDR_W'(OFF_IEN))    bus_rdata = ien_q;
    end

endmodule

// File: rtl/mt_countdown.sv
module mt_countdown
    import mt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              arm,
    input  logic [DATA_W-1:0] arm_value,
    input  logic [DATA_W-1:0] match_q,
    output logic              hit,
    output logic              running,
    output logic [DATA_W-1:0] remaining,
    output logic [DATA_W-1:0] base
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

    cd_state_t         state_q, state_d;
    logic [DATA_W-1:0] rem_q, rem_d;
    logic [DATA_W-1:0] base_q, base_d;

    function automatic logic [DATA_W-1:0] distance(
        input logic [DATA_W-1:0] target,
        input logic [DATA_W-1:0] from
    );
        if (target > from) distance = target - from;
        else               distance = target + (ALL_ONES - from);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CD_IDLE;
            rem_q   <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            base_q  <= base_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        base_d  = base_q;
        hit     = 1'b0;
        unique case (state_q)
            CD_IDLE: begin
                if (arm) begin
                    rem_d   = distance(arm_value, base_q);
                    state_d = CD_RUN;
                end
            end
            CD_RUN: begin
                if (arm) begin
                    rem_d   = distance(arm_value, base_q);
                    state_d = CD_RUN;
                end else if (tick_en) begin
                    if (rem_q <= ONE) begin
                        hit     = 1'b1;
                        rem_d   = '0;
                        base_d  = match_q;
                        state_d = CD_IDLE;
                    end else begin
                        rem_d = rem_q - ONE;
                    end
                end
            end
            default: state_d = CD_IDLE;
        endcase
    end

    assign running   = (state_q == CD_RUN);
    assign remaining = rem_q;
    assign base      = base_q;

endmodule

// File: rtl/mt_status.sv
module mt_status #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] ien_q,
    input  logic              wr_status,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              status,
    output logic              irq
);

    logic status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (hit && (ien_q != '0)) begin
            status_q <= 1'b1;
        end else if (wr_status && (bus_wdata == '0)) begin
            status_q <= 1'b0;
        end
    end

    assign status = status_q;
    assign irq    = status_q;

endmodule

// File: rtl/match_timer.sv
module match_timer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic              wr_match, wr_status;
    logic [DATA_W-1:0] match_q, ien_q, remaining, base;
    logic              hit, running, status;

    mt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .remaining (remaining),
        .status    (status),
        .wr_match  (wr_match),
        .wr_status (wr_status),
        .match_q   (match_q),
        .ien_q     (ien_q),
        .bus_rdata (bus_rdata)
    );

    mt_countdown #(.DATA_W(DATA_W)) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .arm       (wr_match),
        .arm_value (bus_wdata),
        .match_q   (match_q),
        .hit       (hit),
        .running   (running),
        .remaining (remaining),
        .base      (base)
    );

    mt_status #(.DATA_W(DATA_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .ien_q     (ien_q),
        .wr_status (wr_status),
        .bus_wdata (bus_wdata),
        .status    (status),
        .irq       (irq)
    );

endmodule

// File: rtl/mt_checker.sv
module mt_checker
    import mt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              hit,
    input logic              running,
    input logic [DATA_W-1:0] remaining,
    input logic [DATA_W-1:0] base,
    input logic [DATA_W-1:0] match_q,
    input logic [DATA_W-1:0] ien_q
);

    logic mw, sw;
    assign mw = bus_wr && (bus_addr == ADDR_W'(OFF_MATCH));
    assign sw = bus_wr && (bus_addr == ADDR_W'(OFF_STATUS));

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !running && !irq); // R1
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        running && tick_en && !mw && (remaining > DATA_W'(1)) |=> remaining == $past(remaining) - DATA_W'(1)); // R4
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        running && !tick_en && !mw |=> $stable(remaining)); // R4
    AST_HIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (base == $past(match_q)) && !running); // R5
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit) && ($past(ien_q) != '0)); // R6
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq && sw && (bus_wdata == '0) && !hit |=> !irq); // R7
    AST_IEN_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !sw |=> irq); // R8
    AST_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        mw |=> running && !$past(hit)); // R9

endmodule

bind match_timer mt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .hit       (hit),
    .running   (running),
    .remaining (remaining),
    .base      (base),
    .match_q   (match_q),
    .ien_q     (ien_q)
);

// File: tb/sim_match_timer.sv
module sim_match_timer;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_MATCH = 8'h00, A_COUNT = 8'h10, A_STAT = 8'h14, A_IEN = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    match_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, $sformatf("read 0x%02h", a), bus_rdata, exp);
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        rd_check("R1", A_MATCH, 0);
        rd_check("R1", A_COUNT, 0);
        rd_check("R1", A_STAT, 0);
        rd_check("R1", A_IEN, 0);
        check("R1", "irq", irq, 0);
    endtask

    task automatic t_regs();
        wr(A_IEN, 32'hA5A5_0001);
        rd_check("R2", A_IEN, 32'hA5A5_0001);
        wr(A_COUNT, 32'h1234);
        rd_check("R2", A_COUNT, 0);
        wr(8'h08, 32'hFFFF_FFFF);
        rd_check("R2", 8'h08, 0);
        rd_check("R2", 8'h01, 0);
        wr(8'h01, 32'h77);
        rd_check("R2", A_MATCH, 0);
        rd_check("R2", A_STAT, 0);
        rd_check("R2", A_IEN, 32'hA5A5_0001);
    endtask

    task automatic t_basic();
        wr(A_MATCH, 5);
        rd_check("R3", A_COUNT, 0);
        run_ticks(2);
        rd_check("R4", A_COUNT, 2);
        repeat (4) @(negedge clk);
        rd_check("R4", A_COUNT, 2);
        run_ticks(2);
        rd_check("R5", A_COUNT, 4);
        check("R6", "irq before expiry", irq, 0);
        run_ticks(1);
        rd_check("R5", A_COUNT, 5);
        rd_check("R6", A_STAT, 1);
        check("R6", "irq after expiry", irq, 1);
        run_ticks(3);
        rd_check("R5", A_COUNT, 5);
    endtask

    task automatic t_clear();
        wr(A_STAT, 3);
        rd_check("R7", A_STAT, 1);
        wr(A_IEN, 0);
        rd_check("R8", A_STAT, 1);
        check("R8", "irq after ien off", irq, 1);
        wr(A_STAT, 0);
        rd_check("R7", A_STAT, 0);
        check("R7", "irq after clear", irq, 0);
    endtask

    task automatic t_no_ien();
        wr(A_MATCH, 8);
        run_ticks(3);
        rd_check("R5", A_COUNT, 8);
        rd_check("R6", A_STAT, 0);
        check("R6", "irq with ien zero", irq, 0);
    endtask

    task automatic t_wrap();
        wr(A_MATCH, 3);
        rd_check("R3", A_COUNT, 9);
        run_ticks(2);
        rd_check("R4", A_COUNT, 11);
        wr(A_MATCH, 8);
        rd_check("R3", A_COUNT, 9);
    endtask

    task automatic t_rearm();
        wr(A_MATCH, 10);
        rd_check("R9", A_COUNT, 8);
        wr(A_IEN, 1);
        run_ticks(1);
        rd_check("R9", A_COUNT, 9);
        run_ticks(1);
        rd_check("R9", A_COUNT, 10);
        rd_check("R6", A_STAT, 1);
        wr(A_STAT, 0);
    endtask

    task automatic t_collide();
        wr(A_MATCH, 12);
        run_ticks(1);
        @(negedge clk);
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = A_MATCH; bus_wdata = 15;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0;
        rd_check("R9", A_COUNT, 10);
        rd_check("R9", A_STAT, 0);
        run_ticks(5);
        rd_check("R9", A_COUNT, 15);
        rd_check("R6", A_STAT, 1);
    endtask

    task automatic t_set_vs_clear();
        wr(A_MATCH, 17);
        run_ticks(1);
        wr(A_STAT, 0);
        rd_check("R7", A_STAT, 0);
        run_ticks(1);
        rd_check("R7", A_STAT, 1);
        @(negedge clk);
        tick_en = 1'b0;
        wr(A_MATCH, 19);
        run_ticks(1);
        @(negedge clk);
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 0;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0;
        rd_check("R7", A_STAT, 1);
        rd_check("R5", A_COUNT, 19);
        check("R7", "irq after set and clear together", irq, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_basic();
        t_clear();
        t_no_ien();
        t_wrap();
        t_rearm();
        t_collide();
        t_set_vs_clear();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

endmodule